// File: doc/BRIEF.md
# SPI Controller Status and Edge-Interrupt Unit

This unit sits beside an SPI controller's FIFOs and transfer sequencer. It builds a 12-bit live status word from the sequencer's done/ready levels, the two FIFO occupancy counts, and the FIFO push and pop strobes. It also latches FIFO error events into sticky bits. Every 0-to-1 transition of a status bit sets a matching cause bit. Software clears cause bits by writing ones to them. An enable register gates the causes onto a single interrupt line.

The same register bank holds several configuration fields:
- separate 3-bit thresholds that decide when each FIFO counts as "ready";
- a soft-reset bit;
- a flush bit, which issues a one-cycle flush pulse to both FIFOs and reads back as 1 until both FIFOs report empty.

Access is through plain read and write strobes with a 2-bit word address. Register words:
- word 0: status (read only);
- word 1: configuration;
- word 2: cause;
- word 3: enable.

A read returns its data on `bus_rdata` in the cycle after the strobe, and the value is held until the next read. There is no streaming data path, so no back-pressure applies. Every pin is a plain level or single-cycle strobe.

Top module: `spi_stat_irq_unit`

## Requirements
- R1: Status word (word 0, bits 11:0) carries the following bits:
  - bit 0: `seq_done`;
  - bit 1: `seq_ready`;
  - bit 4: read level == 0;
  - bit 5: read level == DEPTH;
  - bit 6: write level == 0;
  - bit 7: write level == DEPTH.
  
  `bus_rdata` shows the addressed word one cycle after `bus_rd` and holds it until the next read.
- R2: Status bit 2 is 1 when read level > read threshold (configuration bits 26:24). Status bit 3 is 1 when DEPTH minus write level > write threshold (configuration bits 30:28). Both thresholds reset to 0.
- R3: A cause bit (word 2) is set on the clock edge where its status bit is 1 and was 0 in the previous cycle. A bit that is already 1 when reset is released, or that stays at 1, never sets its cause.
- R4: Writing word 2 clears every cause bit whose write-data bit is 1. A cause bit that rises on the same edge stays set.
- R5: The enable register (word 3, bits 11:0) resets to 0. `irq` is 1 exactly when some cause bit and its enable bit are both 1, and follows a cause or enable change in the same cycle as the register update.
- R6: Status bits 8, 9, 10 and 11 are sticky error flags:
  - bit 8: read pop while the read FIFO is empty;
  - bit 9: read push while full;
  - bit 10: write pop while empty;
  - bit 11: write push while full.
  
  Each flag is 1 from the cycle after its event until a flush completes or soft reset is held. An event on the clearing edge wins.
- R7: Writing word 1 with bit 9 set while no flush is pending drives `flush_req` high for exactly the next cycle. Configuration bit 9 then reads 1 until an edge (after the pulse) at which both levels are 0. On that edge bit 9 clears and the error flags clear.
- R8: While configuration bit 16 (soft reset) is 1:
  - all cause bits and error flags are held at 0;
  - a pending flush is dropped;
  - no status edge is recorded, and status already high at release raises no cause.
  
  The enable register and thresholds keep their values.
- R9: Word 1 reads back the thresholds and bit 16 as written. Word 3 reads back the enable bits as written. All unused bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 2 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| rd_level | input | LVL_W | Read FIFO occupancy |
| wr_level | input | LVL_W | Write FIFO occupancy |
| rd_push | input | 1 | Read FIFO push strobe |
| rd_pop | input | 1 | Read FIFO pop strobe |
| wr_push | input | 1 | Write FIFO push strobe |
| wr_pop | input | 1 | Write FIFO pop strobe |
| seq_done | input | 1 | Sequencer transfer-done level |
| seq_ready | input | 1 | Sequencer ready-for-transfer level |
| flush_req | output | 1 | One-cycle flush pulse to both FIFOs |
| irq | output | 1 | Interrupt line |

## Verification
The first collision is a status rise and a software clear of the same cause bit on one edge. It is provoked by raising `seq_done` in the cycle in which word 2 is written with that bit set. The cause must survive and `irq` must stay high.

The second collision is flush completion and a FIFO error event on one edge. It is provoked by dropping both levels to zero together with a write-side pop while the flush is pending. The older read-underflow flag must clear and the new write-underflow flag must remain.

A behavioural model in the bench predicts every output on every cycle, so both collisions are judged cycle-exactly as well as by directed reads.

// File: rtl/spi_stat_irq_pkg.sv
package spi_stat_irq_pkg;
  localparam int STAT_W = 12;
  localparam int NERR   = 4;

  // status bit positions
  localparam int S_DONE   = 0;
  localparam int S_READY  = 1;
  localparam int S_RRDY   = 2;
  localparam int S_WRDY   = 3;
  localparam int S_REMPTY = 4;
  localparam int S_RFULL  = 5;
  localparam int S_WEMPTY = 6;
  localparam int S_WFULL  = 7;
  localparam int S_ERR0   = 8;

  // configuration word fields
  localparam int C_FLUSH = 9;
  localparam int C_SRST  = 16;
  localparam int C_RTHR  = 24;
  localparam int C_WTHR  = 28;

  typedef enum logic [1:0] {
    REG_STATUS = 2'd0,
    REG_CONFIG = 2'd1,
    REG_CAUSE  = 2'd2,
    REG_ENABLE = 2'd3
  } reg_sel_e;

  typedef enum logic [1:0] {
    FL_IDLE  = 2'd0,
    FL_PULSE = 2'd1,
    FL_WAIT  = 2'd2
  } flush_st_e;
endpackage

// File: rtl/spi_stat_flags.sv
module spi_stat_flags
  import spi_stat_irq_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int LVL_W = 4,
  parameter int TH_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              srst,
  input  logic              err_clr,
  input  logic [LVL_W-1:0]  rd_level,
  input  logic [LVL_W-1:0]  wr_level,
  input  logic              rd_push,
  input  logic              rd_pop,
  input  logic              wr_push,
  input  logic              wr_pop,
  input  logic              seq_done,
  input  logic              seq_ready,
  input  logic [TH_W-1:0]   rd_thr,
  input  logic [TH_W-1:0]   wr_thr,
  output logic [STAT_W-1:0] stat
);
  localparam int CMP_W = ((LVL_W > TH_W) ? LVL_W : TH_W) + 1;
  localparam logic [CMP_W-1:0] FULL_C = CMP_W'(DEPTH);

  logic [CMP_W-1:0] rd_lvl_c, wr_lvl_c, wr_free_c, rd_thr_c, wr_thr_c;
  logic             rd_empty, rd_full, wr_empty, wr_full;
  logic [NERR-1:0]  err_evt, err_vec;

  assign rd_lvl_c  = CMP_W'(rd_level);
  assign wr_lvl_c  = CMP_W'(wr_level);
  assign wr_free_c = FULL_C - wr_lvl_c;
  assign rd_thr_c  = CMP_W'(rd_thr);
  assign wr_thr_c  = CMP_W'(wr_thr);

  assign rd_empty = (rd_lvl_c == '0);
  assign rd_full  = (rd_lvl_c == FULL_C);
  assign wr_empty = (wr_lvl_c == '0);
  assign wr_full  = (wr_lvl_c == FULL_C);

  // error events in flag order: rd under, rd over, wr under, wr over
  assign err_evt = {wr_push & wr_full, wr_pop & wr_empty,
                    rd_push & rd_full, rd_pop & rd_empty};

  for (genvar g = 0; g < NERR; g++) begin : g_err
    logic flag_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          flag_q <= 1'b0;
      else if (srst)       flag_q <= 1'b0;
      else if (err_evt[g]) flag_q <= 1'b1;
      else if (err_clr)    flag_q <= 1'b0;
    end
    assign err_vec[g] = flag_q;
  end

  always_comb begin
    stat                       = '0;
    stat[S_DONE]               = seq_done;
    stat[S_READY]              = seq_ready;
    stat[S_RRDY]               = (rd_lvl_c > rd_thr_c);
    stat[S_WRDY]               = (wr_free_c > wr_thr_c);
    stat[S_REMPTY]             = rd_empty;
    stat[S_RFULL]              = rd_full;
    stat[S_WEMPTY]             = wr_empty;
    stat[S_WFULL]              = wr_full;
    stat[S_ERR0 +: NERR]       = err_vec;
  end
endmodule

// File: rtl/spi_irq_cause.sv
module spi_irq_cause #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         srst,
  input  logic [W-1:0] stat,
  input  logic         clr_we,
  input  logic [W-1:0] clr_bits,
  input  logic         en_we,
  input  logic [W-1:0] en_bits,
  output logic [W-1:0] cause,
  output logic [W-1:0] enable,
  output logic [W-1:0] rise,
  output logic         irq
);
  logic [W-1:0] prev_q, cause_q, en_q, clr_eff;

  assign rise    = stat & ~prev_q;
  assign clr_eff = clr_we ? clr_bits : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= '1;
      cause_q <= '0;
    end else if (srst) begin
      prev_q  <= '1;
      cause_q <= '0;
    end else begin
      prev_q  <= stat;
      cause_q <= (cause_q & ~clr_eff) | rise;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= '0;
    else if (en_we) en_q <= en_bits;
  end

  assign cause  = cause_q;
  assign enable = en_q;
  assign irq    = |(cause_q & en_q);
endmodule

// File: rtl/spi_flush_ctl.sv
module spi_flush_ctl
  import spi_stat_irq_pkg::*;
#(
  parameter int LVL_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             srst,
  input  logic             start,
  input  logic [LVL_W-1:0] rd_level,
  input  logic [LVL_W-1:0] wr_level,
  output logic             busy,
  output logic             pulse,
  output logic             done
);
  flush_st_e st_q, st_d;

  assign done  = (st_q == FL_WAIT) && (rd_level == '0) && (wr_level == '0);
  assign busy  = (st_q != FL_IDLE);
  assign pulse = (st_q == FL_PULSE);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      FL_IDLE:  if (start) st_d = FL_PULSE;
      FL_PULSE: st_d = FL_WAIT;
      FL_WAIT:  if (done) st_d = FL_IDLE;
      default:  st_d = FL_IDLE;
    endcase
    if (srst) st_d = FL_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= FL_IDLE;
    else        st_q <= st_d;
  end
endmodule

// File: rtl/spi_stat_irq_unit.sv
module spi_stat_irq_unit
  import spi_stat_irq_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int TH_W  = 3,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [1:0]       bus_addr,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  input  logic [LVL_W-1:0] rd_level,
  input  logic [LVL_W-1:0] wr_level,
  input  logic             rd_push,
  input  logic             rd_pop,
  input  logic             wr_push,
  input  logic             wr_pop,
  input  logic             seq_done,
  input  logic             seq_ready,
  output logic             flush_req,
  output logic             irq
);
  reg_sel_e          sel;
  logic              wr_cfg, wr_cause, wr_en;
  logic [TH_W-1:0]   rd_thr_q, wr_thr_q;
  logic              srst_q;
  logic              fl_busy, fl_done, fl_start;
  logic [STAT_W-1:0] stat_w, cause_w, enable_w, rise_w;
  logic [31:0]       rd_mux, rdata_q;

  assign sel      = reg_sel_e'(bus_addr);
  assign wr_cfg   = bus_wr && (sel == REG_CONFIG);
  assign wr_cause = bus_wr && (sel == REG_CAUSE);
  assign wr_en    = bus_wr && (sel == REG_ENABLE);
  assign fl_start = wr_cfg && bus_wdata[C_FLUSH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_thr_q <= '0;
      wr_thr_q <= '0;
      srst_q   <= 1'b0;
    end else if (wr_cfg) begin
      rd_thr_q <= bus_wdata[C_RTHR +: TH_W];
      wr_thr_q <= bus_wdata[C_WTHR +: TH_W];
      srst_q   <= bus_wdata[C_SRST];
    end
  end

  spi_stat_flags #(.DEPTH(DEPTH), .LVL_W(LVL_W), .TH_W(TH_W)) u_flags (
    .clk(clk), .rst_n(rst_n), .srst(srst_q), .err_clr(fl_done),
    .rd_level(rd_level), .wr_level(wr_level),
    .rd_push(rd_push), .rd_pop(rd_pop), .wr_push(wr_push), .wr_pop(wr_pop),
    .seq_done(seq_done), .seq_ready(seq_ready),
    .rd_thr(rd_thr_q), .wr_thr(wr_thr_q), .stat(stat_w)
  );

  spi_irq_cause #(.W(STAT_W)) u_cause (
    .clk(clk), .rst_n(rst_n), .srst(srst_q), .stat(stat_w),
    .clr_we(wr_cause), .clr_bits(bus_wdata[STAT_W-1:0]),
    .en_we(wr_en), .en_bits(bus_wdata[STAT_W-1:0]),
    .cause(cause_w), .enable(enable_w), .rise(rise_w), .irq(irq)
  );

  spi_flush_ctl #(.LVL_W(LVL_W)) u_flush (
    .clk(clk), .rst_n(rst_n), .srst(srst_q), .start(fl_start),
    .rd_level(rd_level), .wr_level(wr_level),
    .busy(fl_busy), .pulse(flush_req), .done(fl_done)
  );

  always_comb begin
    rd_mux = '0;
    unique case (sel)
      REG_STATUS: rd_mux[STAT_W-1:0] = stat_w;
      REG_CONFIG: begin
        rd_mux[C_RTHR +: TH_W] = rd_thr_q;
        rd_mux[C_WTHR +: TH_W] = wr_thr_q;
        rd_mux[C_SRST]         = srst_q;
        rd_mux[C_FLUSH]        = fl_busy;
      end
      REG_CAUSE:  rd_mux[STAT_W-1:0] = cause_w;
      REG_ENABLE: rd_mux[STAT_W-1:0] = enable_w;
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata_q <= '0;
    else if (bus_rd) rdata_q <= rd_mux;
  end
  assign bus_rdata = rdata_q;
endmodule

// File: rtl/spi_stat_irq_chk.sv
module spi_stat_irq_chk
  import spi_stat_irq_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [1:0]        bus_addr,
  input logic [31:0]       bus_wdata,
  input logic [STAT_W-1:0] stat,
  input logic [STAT_W-1:0] cause,
  input logic [STAT_W-1:0] enable,
  input logic [STAT_W-1:0] rise,
  input logic              srst,
  input logic              fl_done,
  input logic              flush_req,
  input logic              irq
);
  // R3: new cause bits only where a status rise was seen
  p_cause_from_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((cause & ~$past(cause) & ~$past(rise)) == '0));

  // R4: cleared bits stay clear unless they rose on the same edge
  p_w1c_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 2'd2) |=>
      ((cause & $past(bus_wdata[STAT_W-1:0]) & ~$past(rise)) == '0));

  // R5: interrupt needs an enabled bit
  p_irq_needs_enable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (enable != '0));

  // R5: writing an all-zero enable silences the line
  p_zero_enable_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 2'd3 && bus_wdata[STAT_W-1:0] == '0) |=> !irq);

  // R6: error flags persist without flush completion or soft reset
  p_err_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!srst && !fl_done) |=>
      ((stat[STAT_W-1:S_ERR0] & $past(stat[STAT_W-1:S_ERR0])) == $past(stat[STAT_W-1:S_ERR0])));

  // R7: flush pulse lasts one cycle
  p_flush_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    flush_req |=> !flush_req);

  // R8: soft reset empties the cause register
  p_srst_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    srst |=> (cause == '0));
endmodule

bind spi_stat_irq_unit spi_stat_irq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .stat(stat_w), .cause(cause_w), .enable(enable_w),
  .rise(rise_w), .srst(srst_q), .fl_done(fl_done), .flush_req(flush_req),
  .irq(irq)
);

// File: tb/sim_spi_stat_irq_unit.sv
module sim_spi_stat_irq_unit;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 8;
  localparam int LVL_W      = $clog2(DEPTH + 1);
  localparam int WATCHDOG   = 20000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_wr = 0, bus_rd = 0;
  logic [1:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic [LVL_W-1:0] rd_level = 0, wr_level = 0;
  logic rd_push = 0, rd_pop = 0, wr_push = 0, wr_pop = 0;
  logic seq_done = 0, seq_ready = 0;
  logic flush_req, irq;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_stat_irq_unit #(.DEPTH(DEPTH), .TH_W(3)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rd_level(rd_level), .wr_level(wr_level), .rd_push(rd_push),
    .rd_pop(rd_pop), .wr_push(wr_push), .wr_pop(wr_pop),
    .seq_done(seq_done), .seq_ready(seq_ready),
    .flush_req(flush_req), .irq(irq)
  );

  int checks = 0, failures = 0, cycles = 0;
  string cur_req = "R1";

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [11:0] m_cause, m_en, m_prev;
  logic [3:0]  m_err;
  int          m_rthr, m_wthr, m_fst;
  logic        m_srst;
  logic [31:0] m_rdata;

  function automatic logic [11:0] m_stat();
    logic [11:0] s;
    int rl = int'(rd_level);
    int wl = int'(wr_level);
    s = '0;
    s[0] = seq_done;
    s[1] = seq_ready;
    s[2] = rl > m_rthr;
    s[3] = (DEPTH - wl) > m_wthr;
    s[4] = rl == 0;
    s[5] = rl == DEPTH;
    s[6] = wl == 0;
    s[7] = wl == DEPTH;
    s[11:8] = m_err;
    return s;
  endfunction

  function automatic logic [31:0] m_read(input logic [1:0] a, input logic [11:0] s);
    logic [31:0] v = '0;
    case (a)
      2'd0: v[11:0] = s;
      2'd1: begin
        v[26:24] = 3'(m_rthr);
        v[30:28] = 3'(m_wthr);
        v[16] = m_srst;
        v[9] = (m_fst != 0);
      end
      2'd2: v[11:0] = m_cause;
      default: v[11:0] = m_en;
    endcase
    return v;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cause = '0; m_en = '0; m_prev = '1; m_err = '0;
      m_rthr = 0; m_wthr = 0; m_fst = 0; m_srst = 0; m_rdata = '0;
    end else begin
      logic [11:0] st;
      logic [3:0] ev;
      logic fdone;
      int rl, wl;
      rl = int'(rd_level);
      wl = int'(wr_level);
      st = m_stat();
      ev = {wr_push && wl == DEPTH, wr_pop && wl == 0,
            rd_push && rl == DEPTH, rd_pop && rl == 0};
      fdone = (m_fst == 2) && rl == 0 && wl == 0;
      if (bus_rd) m_rdata = m_read(bus_addr, st);
      if (m_srst) begin
        m_cause = '0; m_prev = '1; m_err = '0; m_fst = 0;
      end else begin
        if (bus_wr && bus_addr == 2'd2) m_cause = m_cause & ~bus_wdata[11:0];
        m_cause = m_cause | (st & ~m_prev);
        m_prev = st;
        m_err = (fdone ? 4'b0 : m_err) | ev;
        case (m_fst)
          0: if (bus_wr && bus_addr == 2'd1 && bus_wdata[9]) m_fst = 1;
          1: m_fst = 2;
          default: if (fdone) m_fst = 0;
        endcase
      end
      if (bus_wr && bus_addr == 2'd3) m_en = bus_wdata[11:0];
      if (bus_wr && bus_addr == 2'd1) begin
        m_rthr = int'(bus_wdata[26:24]);
        m_wthr = int'(bus_wdata[30:28]);
        m_srst = bus_wdata[16];
      end
    end
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    check("R5", {31'b0, irq}, {31'b0, |(m_cause & m_en)});
    check("R7", {31'b0, flush_req}, {31'b0, m_fst == 1});
    check(cur_req, bus_rdata, m_rdata);
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected<=%0d", cycles, WATCHDOG);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0; bus_wdata = 0;
  endtask

  task automatic rd_exp(input logic [1:0] a, input logic [31:0] msk,
                        input logic [31:0] exp, input string req);
    bus_rd = 1; bus_addr = a;
    @(negedge clk);
    bus_rd = 0;
    check(req, bus_rdata & msk, exp);
  endtask

  localparam logic [31:0] THR = (32'd5 << 28) | (32'd3 << 24);

  initial begin
    cyc(3);
    rst_n = 1;
    cyc(2);
    // R1: reset status: wr-ready, rd empty, wr empty
    cur_req = "R1";
    rd_exp(2'd0, 32'hFFFF_FFFF, 32'h0000_0058, "R1");
    cur_req = "R9";
    rd_exp(2'd1, 32'hFFFF_FFFF, 32'h0, "R9");
    rd_exp(2'd3, 32'hFFFF_FFFF, 32'h0, "R5");
    // R3: bits high at reset release raised nothing
    cur_req = "R3";
    rd_exp(2'd2, 32'hFFFF_FFFF, 32'h0, "R3");
    seq_done = 1;
    cyc(2);
    rd_exp(2'd2, 32'hFFFF_FFFF, 32'h001, "R3");
    // R5: enable after the edge
    cur_req = "R5";
    check("R5", {31'b0, irq}, 32'h0);
    wr(2'd3, 32'h001);
    check("R5", {31'b0, irq}, 32'h1);
    // R4: clear
    cur_req = "R4";
    wr(2'd2, 32'hFFF);
    check("R4", {31'b0, irq}, 32'h0);
    // R4: rise and clear on the same edge
    seq_done = 0;
    cyc(2);
    seq_done = 1;
    wr(2'd2, 32'h001);
    check("R4", {31'b0, irq}, 32'h1);
    rd_exp(2'd2, 32'h001, 32'h001, "R4");
    // R2: thresholds
    cur_req = "R2";
    wr(2'd1, THR);
    rd_level = 4;
    cyc(1);
    rd_exp(2'd0, 32'h4, 32'h4, "R2");
    rd_level = 3;
    cyc(1);
    rd_exp(2'd0, 32'h4, 32'h0, "R2");
    wr_level = 2;
    cyc(1);
    rd_exp(2'd0, 32'h8, 32'h8, "R2");
    wr_level = 3;
    cyc(1);
    rd_exp(2'd0, 32'h8, 32'h0, "R2");
    // R1: full flags
    cur_req = "R1";
    rd_level = 8; wr_level = 8;
    cyc(1);
    rd_exp(2'd0, 32'hF0, 32'hA0, "R1");
    // R6: overflow and underflow, sticky
    cur_req = "R6";
    rd_push = 1; wr_push = 1;
    cyc(1);
    rd_push = 0; wr_push = 0;
    rd_level = 0; rd_pop = 1;
    cyc(1);
    rd_pop = 0; rd_level = 4; wr_level = 2;
    cyc(3);
    rd_exp(2'd0, 32'hF00, 32'hB00, "R6");
    // R5: enable everything, then nothing
    cur_req = "R5";
    wr(2'd3, 32'hFFF);
    cyc(1);
    wr(2'd3, 32'h000);
    check("R5", {31'b0, irq}, 32'h0);
    // R7: flush
    cur_req = "R7";
    wr(2'd1, THR | 32'h200);
    check("R7", {31'b0, flush_req}, 32'h1);
    cyc(1);
    check("R7", {31'b0, flush_req}, 32'h0);
    cyc(2);
    rd_exp(2'd1, 32'h200, 32'h200, "R7");
    rd_level = 0; wr_level = 0; wr_pop = 1;
    cyc(1);
    wr_pop = 0;
    cyc(1);
    rd_exp(2'd1, 32'h200, 32'h0, "R7");
    rd_exp(2'd0, 32'hF00, 32'h400, "R6");
    // R8: soft reset
    cur_req = "R8";
    wr(2'd3, 32'h002);
    seq_ready = 1;
    cyc(2);
    check("R8", {31'b0, irq}, 32'h1);
    wr(2'd1, THR | 32'h1_0000);
    cyc(1);
    check("R8", {31'b0, irq}, 32'h0);
    rd_exp(2'd2, 32'hFFF, 32'h0, "R8");
    seq_ready = 0; seq_done = 0;
    cyc(2);
    seq_ready = 1; seq_done = 1;
    cyc(2);
    wr(2'd1, THR);
    cyc(3);
    rd_exp(2'd2, 32'hFFF, 32'h0, "R8");
    rd_exp(2'd3, 32'hFFF, 32'h002, "R8");
    // R9: readback
    cur_req = "R9";
    wr(2'd3, 32'hABC);
    rd_exp(2'd3, 32'hFFFF_FFFF, 32'h0000_0ABC, "R9");
    rd_exp(2'd1, 32'hFFFF_FFFF, THR, "R9");
    // R3: a further edge after everything
    cur_req = "R3";
    wr(2'd3, 32'h000);
    wr(2'd2, 32'hFFF);
    seq_ready = 0;
    cyc(2);
    seq_ready = 1;
    cyc(2);
    rd_exp(2'd2, 32'h002, 32'h002, "R3");
    cyc(2);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule